// File: doc/BRIEF.md
# Pin-Triggered Conversion Sequencer

This block is the digital control engine of an eight-channel sampling converter running in pin-triggered mode. A start input from outside the chip is synchronized and watched for edges. A rising edge wakes the converter out of its low-power sleep state and starts the power-up interval, which also covers acquisition. A falling edge puts the sampler into hold and starts a conversion of fixed length. When the conversion ends, the block drops back to sleep and waits for the next rising edge. The power-up and conversion intervals are counted in system clock cycles, and both are derived from parameters that give the clock rate and the two durations in nanoseconds.

The channel to convert comes from an eight-bit enable mask. With several bits set, each start pulse converts the next enabled channel, so a run of pulses walks the enabled channels. If the start pulse was too short for the converter to finish powering up, the conversion still runs, but its result is marked not valid. The analog core is a deterministic stand-in that returns a code computed from the channel number. Results are read through a simple registered read port instead of a serial bus.

Top module: `conv_pulse_seq`

## Requirements
- R1: After reset, busy is low and rd_data reads 0, both before and after a read request.
- R2: When start pulses are enabled, busy is low two clock edges after start_in rises and high from the third edge on.
- R3: busy falls exactly CONV_CYC+3 clock edges after start_in falls, where CONV_CYC = CLK_MHZ*CONV_NS/1000. The new result is stored on that same edge.
- R4: If start_in stays high for at least PWRUP_CYC sampling edges (PWRUP_CYC = CLK_MHZ*PWRUP_NS/1000), the stored result has its valid bit set.
- R5: A shorter high pulse still runs a full conversion, but the stored result has its valid bit cleared.
- R6: The stored code is (channel*113 + 37) mod 1024.
- R7: Channels are taken in ascending order starting from channel 0 after reset. Each pulse converts the lowest enabled channel at or above the one after the last converted channel, wrapping to the lowest enabled channel. The mask bit index is the channel number.
- R8: With an all-zero chan_mask, a start pulse does nothing: busy stays low and the stored result is unchanged.
- R9: If cyc_timer or mode_sel is non-zero, start pulses are ignored and the channel sequence does not advance.
- R10: rd_data is loaded from the result register on the edge after rd_en is sampled high and holds its value while rd_en is low. Bit 15 is the valid bit, bits 14:13 are zero, bits 12:10 are the channel and bits 9:0 are the code.
- R11: Start edges that arrive during a conversion do not lengthen it, do not restart it and do not advance the channel sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Asynchronous convert-start pulse |
| chan_mask | input | 8 | Channel enable mask, bit n enables channel n |
| cyc_timer | input | 3 | Cycle-timer setting; must be zero for pin-triggered mode |
| mode_sel | input | 4 | Mode-select bits; must be zero for pin-triggered mode |
| rd_en | input | 1 | Read request for the result register |
| rd_data | output | 16 | Registered read data {valid, 2'b00, channel, code} |
| busy | output | 1 | High from an accepted rising edge until shutdown |

## Verification
If the sequencer state is wrong, the channel field of the very next result read shows it, because every conversion exposes which channel was picked. If a counter is off, the busy fall moves away from CONV_CYC+3 edges, or the valid bit flips at the 199/200-cycle pulse boundary, and this shows within one pulse. A control state that leaked out of sleep would show busy rising on a pulse that should have been ignored. A missed gate would show the sequence skipping a channel on the next accepted pulse.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;

    localparam int CH_N     = 8;
    localparam int CH_W     = $clog2(CH_N);
    localparam int CODE_W   = 10;
    localparam int RD_W     = 16;
    localparam int PAD_W    = RD_W - 1 - CH_W - CODE_W;
    localparam int STUB_MUL = 113;
    localparam int STUB_OFS = 37;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_PWRUP = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              ok;
        logic [CH_W-1:0]   ch;
        logic [CODE_W-1:0] code;
    } sample_t;

    function automatic logic [CODE_W-1:0] stub_code(input logic [CH_W-1:0] ch);
        logic [31:0] t;
        t = 32'(ch) * 32'(STUB_MUL) + 32'(STUB_OFS);
        return t[CODE_W-1:0];
    endfunction

    function automatic logic [RD_W-1:0] pack_rd(input sample_t s);
        return {s.ok, {PAD_W{1'b0}}, s.ch, s.code};
    endfunction

endpackage

// File: rtl/cps_sync_edge.sv
`timescale 1ns/1ps
module cps_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[LAST-1:0], din};
    end

    // sh[LAST-1] is the synchronized level, sh[LAST] its previous value
    assign rise = sh[LAST-1] & ~sh[LAST];
    assign fall = ~sh[LAST-1] & sh[LAST];

endmodule

// File: rtl/cps_chan_seq.sv
`timescale 1ns/1ps
module cps_chan_seq
    import cps_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_N-1:0] mask,
    input  logic            load,
    input  logic            advance,
    output logic [CH_W-1:0] cur_ch,
    output logic            any_en
);
    logic [CH_W-1:0] ptr;
    logic [CH_W-1:0] nxt;

    function automatic logic [CH_W-1:0] pick(input logic [CH_N-1:0] m,
                                            input logic [CH_W-1:0] from);
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] idx;
        logic            hit;
        r   = from;
        hit = 1'b0;
        for (int k = 0; k < CH_N; k++) begin
            idx = CH_W'((int'(from) + k) % CH_N);
            if (!hit && m[idx]) begin
                r   = idx;
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    assign nxt    = pick(mask, ptr);
    assign any_en = |mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            cur_ch <= '0;
        end else begin
            if (load)
                cur_ch <= nxt;
            if (advance)
                ptr <= (cur_ch == CH_W'(CH_N-1)) ? '0 : cur_ch + 1'b1;
        end
    end

    // R7: the picked channel is always enabled in the mask
    a_r7_pick_enabled: assert property (@(posedge clk) disable iff (rst)
        load |-> mask[nxt]);

    // R7: the pointer only moves on completion
    a_r7_ptr_stable: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(ptr));

endmodule

// File: rtl/cps_timing_fsm.sv
`timescale 1ns/1ps
module cps_timing_fsm
    import cps_pkg::*;
#(
    parameter int PWRUP_CYC = 200,
    parameter int CONV_CYC  = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic fall,
    input  logic gate_ok,
    output logic accept,
    output logic hold,
    output logic done,
    output logic busy,
    output logic pwr_ok
);
    localparam int PW_W = $clog2(PWRUP_CYC + 1);
    localparam int CV_W = $clog2(CONV_CYC + 1);

    seq_state_e      state;
    logic [PW_W-1:0] pw_cnt;
    logic [CV_W-1:0] cv_cnt;

    assign accept = (state == ST_SLEEP) && rise && gate_ok;
    assign hold   = (state == ST_PWRUP) && fall;
    assign done   = (state == ST_CONV) && (cv_cnt == CV_W'(CONV_CYC));
    assign busy   = (state != ST_SLEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_SLEEP;
            pw_cnt <= '0;
            cv_cnt <= '0;
            pwr_ok <= 1'b0;
        end else begin
            unique case (state)
                ST_SLEEP: begin
                    if (accept) begin
                        state  <= ST_PWRUP;
                        pw_cnt <= PW_W'(1);
                    end
                end
                ST_PWRUP: begin
                    if (hold) begin
                        state  <= ST_CONV;
                        cv_cnt <= CV_W'(1);
                        pwr_ok <= (pw_cnt >= PW_W'(PWRUP_CYC));
                    end else if (pw_cnt != PW_W'(PWRUP_CYC)) begin
                        pw_cnt <= pw_cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (done) state <= ST_SLEEP;
                    else      cv_cnt <= cv_cnt + 1'b1;
                end
                default: state <= ST_SLEEP;
            endcase
        end
    end

    // R2: an accepted rising edge raises busy on the next edge
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R3: completion returns to sleep
    a_r3_done_sleep: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == ST_SLEEP));

    // R3: conversion counter never passes its limit
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cv_cnt <= CV_W'(CONV_CYC));

    // R8, R9: a gated-off sleep stays asleep
    a_r9_gate_sleep: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !gate_ok) |=> !busy);

    // R11: edges during conversion never restart power-up
    a_r11_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV) |=> (state != ST_PWRUP));

endmodule

// File: rtl/cps_adc_stub.sv
`timescale 1ns/1ps
module cps_adc_stub
    import cps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [CH_W-1:0]   ch,
    output logic [CODE_W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst)       code <= '0;
        else if (hold) code <= stub_code(ch);
    end
endmodule

// File: rtl/conv_pulse_seq.sv
`timescale 1ns/1ps
module conv_pulse_seq
    import cps_pkg::*;
#(
    parameter int CLK_MHZ  = 200,
    parameter int PWRUP_NS = 1000,
    parameter int CONV_NS  = 2000,
    parameter int SYNC_N   = 2,
    parameter int CT_W     = 3,
    parameter int MS_W     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_in,
    input  logic [CH_N-1:0] chan_mask,
    input  logic [CT_W-1:0] cyc_timer,
    input  logic [MS_W-1:0] mode_sel,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            busy
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_NS / 1000;
    localparam int CONV_CYC  = CLK_MHZ * CONV_NS / 1000;

    logic              rise, fall;
    logic              accept, hold, done, pwr_ok;
    logic              any_en, gate_ok;
    logic [CH_W-1:0]   cur_ch;
    logic [CODE_W-1:0] held_code;
    sample_t           res;

    assign gate_ok = (cyc_timer == '0) && (mode_sel == '0) && any_en;

    cps_sync_edge #(.STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (start_in),
        .rise(rise),
        .fall(fall)
    );

    cps_chan_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .mask   (chan_mask),
        .load   (accept),
        .advance(done),
        .cur_ch (cur_ch),
        .any_en (any_en)
    );

    cps_timing_fsm #(.PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .rise   (rise),
        .fall   (fall),
        .gate_ok(gate_ok),
        .accept (accept),
        .hold   (hold),
        .done   (done),
        .busy   (busy),
        .pwr_ok (pwr_ok)
    );

    cps_adc_stub u_stub (
        .clk (clk),
        .rst (rst),
        .hold(hold),
        .ch  (cur_ch),
        .code(held_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res     <= '0;
            rd_data <= '0;
        end else begin
            if (done) begin
                res.ok   <= pwr_ok;
                res.ch   <= cur_ch;
                res.code <= held_code;
            end
            if (rd_en)
                rd_data <= pack_rd(res);
        end
    end

    // R6: the stored code matches the channel it is tagged with
    a_r6_code_match: assert property (@(posedge clk) disable iff (rst)
        done |=> (res.code == stub_code(res.ch)));

    // R4, R5: the valid bit follows the power-up verdict
    a_r4_valid_flag: assert property (@(posedge clk) disable iff (rst)
        done |=> (res.ok == $past(pwr_ok)));

    // R8: result register only changes on completion
    a_r8_res_stable: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(res));

    // R10: read data holds without a request
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/test_conv_pulse_seq.sv
`timescale 1ns/1ps
module test_conv_pulse_seq;

    localparam int PWRUP_CYC = 200;
    localparam int CONV_CYC  = 400;
    localparam int NV        = 8;

    localparam logic [7:0] V_MASK [NV] = '{8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h10, 8'h81, 8'h81};
    localparam int         V_HI   [NV] = '{200,   250,   199,   50,    200,   200,   200,   201};
    localparam int         V_CH   [NV] = '{0,     2,     5,     7,     0,     4,     7,     0};
    localparam bit         V_OK   [NV] = '{1'b1,  1'b1,  1'b0,  1'b0,  1'b1,  1'b1,  1'b1,  1'b1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_in = 1'b0;
    logic [7:0]  chan_mask = 8'h00;
    logic [2:0]  cyc_timer = 3'd0;
    logic [3:0]  mode_sel = 4'd0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        busy;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    conv_pulse_seq i_conv_pulse_seq (
        .clk      (clk),
        .rst      (rst),
        .start_in (start_in),
        .chan_mask(chan_mask),
        .cyc_timer(cyc_timer),
        .mode_sel (mode_sel),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .busy     (busy)
    );

    function automatic logic [15:0] exp_rd(input int ch, input bit ok);
        logic [9:0] c;
        c = 10'((ch * 113 + 37) % 1024);
        return {ok, 2'b00, 3'(ch), c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [15:0] v);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        v = rd_data;
    endtask

    // Drives one start pulse of 'hi' sampling edges and checks busy timing
    task automatic do_conv(input int hi, input bit expect_run);
        int n;
        int stray;
        stray = 0;
        start_in = 1'b1;
        for (int i = 1; i <= hi; i++) begin
            @(negedge clk);
            if (expect_run && i == 2) chk("R2 busy before third edge", 32'(busy), 32'd0);
            if (expect_run && i == 3) chk("R2 busy after third edge", 32'(busy), 32'd1);
            if (!expect_run && busy) stray++;
        end
        start_in = 1'b0;
        if (expect_run) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (busy && n < 5000);
            chk("R3 busy fall delay", 32'(n), 32'(CONV_CYC + 3));
        end else begin
            for (int i = 0; i < CONV_CYC + 10; i++) begin
                @(negedge clk);
                if (busy) stray++;
            end
            chk("R8/R9 busy stayed low on ignored pulse", 32'(stray), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 rd_data after reset", 32'(rd_data), 32'd0);
        do_read(v);
        chk("R1 read after reset", 32'(v), 32'd0);

        // Table walk: R4, R5, R6, R7, R10
        for (int k = 0; k < NV; k++) begin
            chan_mask = V_MASK[k];
            do_conv(V_HI[k], 1'b1);
            do_read(v);
            chk($sformatf("R7/R6/%s vector %0d", V_OK[k] ? "R4" : "R5", k),
                32'(v), 32'(exp_rd(V_CH[k], V_OK[k])));
        end

        // R8: empty mask
        chan_mask = 8'h00;
        do_conv(200, 1'b0);
        do_read(v);
        chk("R8 result unchanged after empty mask", 32'(v), 32'(exp_rd(0, 1'b1)));

        // R9: timer and mode bits gate start pulses
        chan_mask = 8'h81;
        cyc_timer = 3'd1;
        do_conv(200, 1'b0);
        cyc_timer = 3'd0;
        mode_sel  = 4'd2;
        do_conv(200, 1'b0);
        mode_sel  = 4'd0;
        do_read(v);
        chk("R9 result unchanged while gated", 32'(v), 32'(exp_rd(0, 1'b1)));
        do_conv(200, 1'b1);
        do_read(v);
        chk("R9 sequence not advanced by gated pulses", 32'(v), 32'(exp_rd(7, 1'b1)));

        // R11: pulse during conversion is ignored
        start_in = 1'b1;
        repeat (200) @(negedge clk);
        start_in = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 50) start_in = 1'b1;
            if (n == 70) start_in = 1'b0;
        end while (busy && n < 5000);
        chk("R11 conversion length unchanged by retrigger", 32'(n), 32'(CONV_CYC + 3));
        do_read(v);
        chk("R11 result of interrupted-free conversion", 32'(v), 32'(exp_rd(0, 1'b1)));
        do_conv(200, 1'b1);
        do_read(v);
        chk("R11 sequence advanced only once", 32'(v), 32'(exp_rd(7, 1'b1)));

        // R10: rd_data holds without a read request
        do_conv(200, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 rd_data holds without rd_en", 32'(rd_data), 32'(exp_rd(7, 1'b1)));
        do_read(v);
        chk("R10 read after hold shows new result", 32'(v), 32'(exp_rd(0, 1'b1)));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule